// File: doc/BRIEF.md
# Periodic Snapshot Capture Buffer

This block watches a stream of processed baseband sample sets. Each set carries five 16-bit quantities: in-phase (I) and quadrature (Q) in two's complement, magnitude as unsigned, phase, and frequency in two's complement. The block does not keep every set. On a programmed period it copies a short burst of consecutive sets into a small dual-port store. When the burst is complete it raises a data-ready flag, which a host uses as an interrupt. The host then reads the store one byte at a time, choosing a sample slot, a quantity and a byte half.

The period is counted in accepted sample strobes, from the first set of one burst to the first set of the next. Its value is an 8-bit field plus one. The field sits in bits 11 down to 4 of a 16-bit configuration word, with bit 11 as the most significant bit. Tracking loops that need a few neighbouring samples now and then can use this to avoid handling the full sample rate.

The input side is a valid/ready stream. `in_ready` is held high at all times, so the block never applies back-pressure. A set is accepted on any clock edge where `in_valid` is high. Configuration, acknowledge and read-select pins are plain level or strobe signals.

Top module: `snap_capture_top`

## Requirements
- R1: A synchronous active-high reset clears data-ready. The first accepted set after reset opens a burst and is stored in slot 0.
- R2: Bursts start every P accepted sets, where P is the value of `cfg_word[11:4]` plus one. Bit 11 is the most significant bit of that field, and the other bits of `cfg_word` have no effect.
- R3: A field value of 255 gives a period of 256 accepted sets.
- R4: A burst stores SET_LEN (default 4) consecutive accepted sets in slots 0 to SET_LEN-1, in arrival order. Cycles with `in_valid` low store nothing and do not advance the period count.
- R5: The host read output `host_rd_data` is combinational. Its word-select code picks the quantity: 0=I, 1=Q, 2=magnitude, 3=phase, 4=frequency. Byte select 0 returns bits 7:0 and byte select 1 returns bits 15:8. `host_sample_sel` picks the slot.
- R6: Word-select codes 5, 6 and 7 read as zero.
- R7: `data_ready` goes high in the cycle after the last set of a burst is accepted.
- R8: A one-cycle `host_ack` clears `data_ready` from the next cycle on.
- R9: The start of the next burst also clears `data_ready`. A burst completing in the same cycle as the clear wins over it.
- R10: When P is smaller than SET_LEN, the next burst starts on the set that follows the last set of the current burst. The effective spacing is therefore SET_LEN.
- R11: A `cfg_wr` strobe loads the field and restarts the period. The next burst starts on the first accepted set after the write, once any burst in progress has finished.
- R12: `in_ready` is high in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample set valid |
| in_ready | output | 1 | Always 1: no back-pressure |
| in_i | input | 16 | In-phase, two's complement |
| in_q | input | 16 | Quadrature, two's complement |
| in_mag | input | 16 | Magnitude, unsigned |
| in_phase | input | 16 | Phase |
| in_freq | input | 16 | Frequency, two's complement |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 16 | Configuration word; bits 11:4 hold the period field |
| host_ack | input | 1 | Data-ready acknowledge strobe |
| host_sample_sel | input | 2 | Slot to read |
| host_word_sel | input | 3 | Quantity to read |
| host_byte_sel | input | 1 | 0 = low byte, 1 = high byte |
| host_rd_data | output | 8 | Read byte |
| data_ready | output | 1 | Burst-complete interrupt |

## Verification
The bound checker watches four things on every cycle:
- the spacing between burst starts: P or SET_LEN, whichever is larger, unless a configuration write came in between;
- that unused word codes read as zero;
- that data-ready only rises after an accepted set;
- that data-ready falls after an acknowledge or a burst start, and otherwise holds while the input is idle.

Some behaviours only the bench's scenarios can show. These are the stored contents of each slot compared with the sets that were actually sent, the handling of invalid cycles carrying junk data, and the restart after a configuration write. The bench shows them by sweeping many period values, with and without input gaps, and dumping every slot, word and byte at each interrupt.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int NUM_Q = 5;
  localparam int QSEL_W = 3;

  typedef enum logic [QSEL_W-1:0] {
    QS_I     = 3'd0,
    QS_Q     = 3'd1,
    QS_MAG   = 3'd2,
    QS_PHASE = 3'd3,
    QS_FREQ  = 3'd4
  } qsel_e;
endpackage

// File: rtl/snap_sched.sv
module snap_sched #(
  parameter int FIELD_W   = 8,
  parameter int SET_LEN   = 4,
  parameter int RST_FIELD = 3,
  parameter int SLOT_W    = (SET_LEN > 1) ? $clog2(SET_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  input  logic               cfg_wr,
  input  logic [FIELD_W-1:0] cfg_field,
  input  logic               host_ack,
  output logic               wr_en,
  output logic [SLOT_W-1:0]  wr_slot,
  output logic               cap_start,
  output logic               data_ready
);
  localparam int CNT_W = FIELD_W + 1;
  localparam logic [CNT_W-1:0]  GAP_SAT  = {1'b1, {FIELD_W{1'b0}}};
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SET_LEN - 1);

  logic [FIELD_W-1:0] field_q;
  logic [CNT_W-1:0]   gap_q;
  logic [CNT_W-1:0]   period;
  logic               pend_q, busy_q, ready_q;
  logic [SLOT_W-1:0]  idx_q;
  logic               can_start, in_set, last;

  always_comb begin
    period    = CNT_W'(field_q) + CNT_W'(1);
    can_start = !busy_q && (pend_q || (gap_q >= period));
    cap_start = smp_valid && can_start;
    in_set    = smp_valid && (busy_q || can_start);
    wr_slot   = busy_q ? idx_q : '0;
    last      = in_set && (wr_slot == LAST_SLOT);
  end

  assign wr_en      = in_set;
  assign data_ready = ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= FIELD_W'(RST_FIELD);
      gap_q   <= '0;
      pend_q  <= 1'b1;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      if (cap_start) pend_q <= 1'b0;
      if (cfg_wr) begin
        field_q <= cfg_field;
        pend_q  <= 1'b1;
      end
      if (smp_valid) begin
        if (cap_start)
          gap_q <= CNT_W'(1);
        else if (gap_q != GAP_SAT)
          gap_q <= gap_q + CNT_W'(1);
      end
      if (in_set) begin
        if (last) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= wr_slot + SLOT_W'(1);
        end
      end
      if (last)
        ready_q <= 1'b1;
      else if (host_ack || cap_start)
        ready_q <= 1'b0;
    end
  end
endmodule

// File: rtl/snap_buf.sv
module snap_buf #(
  parameter int DATA_W  = 16,
  parameter int SET_LEN = 4,
  parameter int NUM_Q   = snap_pkg::NUM_Q,
  parameter int SLOT_W  = (SET_LEN > 1) ? $clog2(SET_LEN) : 1,
  parameter int QSEL_W  = snap_pkg::QSEL_W
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [SLOT_W-1:0]            wr_slot,
  input  logic [NUM_Q-1:0][DATA_W-1:0] wr_words,
  input  logic [SLOT_W-1:0]            rd_slot,
  input  logic [QSEL_W-1:0]            rd_word,
  output logic [DATA_W-1:0]            rd_data
);
  logic [DATA_W-1:0] mem [SET_LEN][NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_slot][q] <= wr_words[q];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < SET_LEN; s++) begin
      for (int q = 0; q < NUM_Q; q++) begin
        if (rd_slot == SLOT_W'(s) && rd_word == QSEL_W'(q))
          rd_data = mem[s][q];
      end
    end
  end
endmodule

// File: rtl/snap_byte_sel.sv
module snap_byte_sel #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NBYTES = DATA_W / BYTE_W,
  parameter int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic [DATA_W-1:0] word,
  input  logic [BSEL_W-1:0] sel,
  output logic [BYTE_W-1:0] byte_out
);
  always_comb begin
    byte_out = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (sel == BSEL_W'(b)) byte_out = word[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/snap_capture_top.sv
module snap_capture_top #(
  parameter int DATA_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int SET_LEN   = 4,
  parameter int CFG_W     = 16,
  parameter int FIELD_W   = 8,
  parameter int FIELD_LSB = 4,
  parameter int RST_FIELD = 3
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         in_valid,
  output logic                                         in_ready,
  input  logic [DATA_W-1:0]                            in_i,
  input  logic [DATA_W-1:0]                            in_q,
  input  logic [DATA_W-1:0]                            in_mag,
  input  logic [DATA_W-1:0]                            in_phase,
  input  logic [DATA_W-1:0]                            in_freq,
  input  logic                                         cfg_wr,
  input  logic [CFG_W-1:0]                             cfg_word,
  input  logic                                         host_ack,
  input  logic [((SET_LEN > 1) ? $clog2(SET_LEN) : 1)-1:0] host_sample_sel,
  input  logic [snap_pkg::QSEL_W-1:0]                  host_word_sel,
  input  logic [((DATA_W/BYTE_W > 1) ? $clog2(DATA_W/BYTE_W) : 1)-1:0] host_byte_sel,
  output logic [BYTE_W-1:0]                            host_rd_data,
  output logic                                         data_ready
);
  import snap_pkg::*;

  localparam int SLOT_W = (SET_LEN > 1) ? $clog2(SET_LEN) : 1;
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic                         smp_valid;
  logic                         wr_en, cap_start;
  logic [SLOT_W-1:0]            wr_slot;
  logic [NUM_Q-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]            rd_word_data;

  assign in_ready  = 1'b1;
  assign smp_valid = in_valid && in_ready;

  always_comb begin
    words[QS_I]     = in_i;
    words[QS_Q]     = in_q;
    words[QS_MAG]   = in_mag;
    words[QS_PHASE] = in_phase;
    words[QS_FREQ]  = in_freq;
  end

  snap_sched #(
    .FIELD_W(FIELD_W), .SET_LEN(SET_LEN), .RST_FIELD(RST_FIELD), .SLOT_W(SLOT_W)
  ) sched_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .cfg_wr(cfg_wr),
    .cfg_field(cfg_word[FIELD_LSB +: FIELD_W]), .host_ack(host_ack),
    .wr_en(wr_en), .wr_slot(wr_slot), .cap_start(cap_start),
    .data_ready(data_ready)
  );

  snap_buf #(
    .DATA_W(DATA_W), .SET_LEN(SET_LEN), .NUM_Q(NUM_Q), .SLOT_W(SLOT_W),
    .QSEL_W(QSEL_W)
  ) buf_i (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_words(words),
    .rd_slot(host_sample_sel), .rd_word(host_word_sel), .rd_data(rd_word_data)
  );

  snap_byte_sel #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES), .BSEL_W(BSEL_W)
  ) bsel_i (
    .word(rd_word_data), .sel(host_byte_sel), .byte_out(host_rd_data)
  );
endmodule

// File: rtl/snap_chk.sv
module snap_chk #(
  parameter int SET_LEN   = 4,
  parameter int CFG_W     = 16,
  parameter int FIELD_W   = 8,
  parameter int FIELD_LSB = 4,
  parameter int RST_FIELD = 3,
  parameter int BYTE_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              cfg_wr,
  input logic [CFG_W-1:0]  cfg_word,
  input logic              host_ack,
  input logic [2:0]        host_word_sel,
  input logic [BYTE_W-1:0] host_rd_data,
  input logic              data_ready,
  input logic              cap_start
);
  localparam int GC_W = FIELD_W + 2;
  localparam logic [GC_W-1:0] GC_SAT = {2'b10, {FIELD_W{1'b0}}};

  logic [FIELD_W-1:0] field_c;
  logic [GC_W-1:0]    gap_c;
  logic               started, wr_seen;
  int                 exp_gap;

  always_comb begin
    exp_gap = int'(field_c) + 1;
    if (exp_gap < SET_LEN) exp_gap = SET_LEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_c <= FIELD_W'(RST_FIELD);
      gap_c   <= '0;
      started <= 1'b0;
      wr_seen <= 1'b0;
    end else begin
      if (cap_start) begin
        started <= 1'b1;
        wr_seen <= 1'b0;
        gap_c   <= GC_W'(1);
      end else if (in_valid && gap_c != GC_SAT) begin
        gap_c <= gap_c + GC_W'(1);
      end
      if (cfg_wr) begin
        field_c <= cfg_word[FIELD_LSB +: FIELD_W];
        wr_seen <= 1'b1;
      end
    end
  end

  // R2 R3 R10: burst starts are spaced by max(P, SET_LEN) accepted sets
  a_r2_start_spacing: assert property (@(posedge clk) disable iff (rst)
    (cap_start && started && !wr_seen) |-> (int'(gap_c) == exp_gap));

  // R6: unused word codes read zero
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (host_word_sel > 3'd4) |-> (host_rd_data == '0));

  // R7: data-ready only rises after an accepted set
  a_r7_rise_after_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(in_valid));

  // R8: acknowledge with an idle input clears data-ready
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (host_ack && !in_valid) |=> !data_ready);

  // R9: a burst start clears data-ready
  a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
    (cap_start && (SET_LEN > 1)) |=> !data_ready);

  // R4: data-ready holds while no set is accepted and no acknowledge arrives
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !host_ack) |=> $stable(data_ready));
endmodule

bind snap_capture_top snap_chk #(
  .SET_LEN(SET_LEN), .CFG_W(CFG_W), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB),
  .RST_FIELD(RST_FIELD), .BYTE_W(BYTE_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_wr(cfg_wr),
  .cfg_word(cfg_word), .host_ack(host_ack), .host_word_sel(host_word_sel),
  .host_rd_data(host_rd_data), .data_ready(data_ready), .cap_start(cap_start)
);

// File: tb/snap_capture_top_tb_top.sv
module snap_capture_top_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_i = '0, in_q = '0, in_mag = '0, in_phase = '0, in_freq = '0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        host_ack = 1'b0;
  logic [1:0]  host_sample_sel = '0;
  logic [2:0]  host_word_sel = '0;
  logic [0:0]  host_byte_sel = '0;
  logic [7:0]  host_rd_data;
  logic        data_ready;

  int checks = 0;
  int fails = 0;
  int gseq = 0;
  int k = 0;
  int field_m = 3;
  bit dr_exp = 1'b0;
  bit done = 1'b0;
  int set_base = 0;

  always #10 clk = ~clk;

  snap_capture_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .in_mag(in_mag), .in_phase(in_phase),
    .in_freq(in_freq), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .host_ack(host_ack), .host_sample_sel(host_sample_sel),
    .host_word_sel(host_word_sel), .host_byte_sel(host_byte_sel),
    .host_rd_data(host_rd_data), .data_ready(data_ready)
  );

  function automatic logic [15:0] fval(int g, int w);
    logic [15:0] gv = g[15:0];
    case (w)
      0: return 16'hA500 ^ gv;
      1: return gv * 16'd3 + 16'h1000;
      2: return gv * 16'd7;
      3: return ~gv;
      default: return gv * 16'd257 + 16'd5;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 data_ready after reset", int'(data_ready), 0);
    k = 0; dr_exp = 1'b0; field_m = 3; done = 1'b0;
  endtask

  task automatic cfg(input int field);
    cfg_wr = 1'b1;
    cfg_word = {4'hA, field[7:0], 4'h5};
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_word = 16'hFFFF;
    field_m = field;
    k = 0;
    chk("R11 data_ready after cfg write", int'(data_ready), int'(dr_exp));
  endtask

  task automatic sample(input bit v);
    int step, r;
    in_valid = v;
    if (v) begin
      in_i = fval(gseq, 0); in_q = fval(gseq, 1); in_mag = fval(gseq, 2);
      in_phase = fval(gseq, 3); in_freq = fval(gseq, 4);
    end else begin
      in_i = 16'hDEAD; in_q = 16'hBEEF; in_mag = 16'hDEAD;
      in_phase = 16'hBEEF; in_freq = 16'hDEAD;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (v) begin
      step = (field_m + 1 > N) ? field_m + 1 : N;
      r = k % step;
      if (r == N - 1) begin
        dr_exp = 1'b1; set_base = gseq - (N - 1); done = 1'b1;
      end else if (r == 0) begin
        dr_exp = 1'b0;
      end
      k++; gseq++;
    end
    if (dr_exp) chk("R7 data_ready", int'(data_ready), int'(dr_exp));
    else        chk("R9 data_ready", int'(data_ready), int'(dr_exp));
    chk("R12 in_ready", int'(in_ready), 1);
  endtask

  task automatic dump(input int base, input string stag);
    int e;
    for (int s = 0; s < N; s++)
      for (int w = 0; w < 8; w++)
        for (int b = 0; b < 2; b++) begin
          host_sample_sel = s[1:0]; host_word_sel = w[2:0]; host_byte_sel = b[0:0];
          #1;
          if (w < 5) begin
            e = int'(fval(base + s, w) >> (8 * b)) & 8'hFF;
            chk({"R4 R5 ", stag}, int'(host_rd_data), e);
          end else begin
            chk("R6 unused word", int'(host_rd_data), 0);
          end
        end
  endtask

  task automatic run(input int field, input int nsets, input int gap_every,
                     input string stag, input bit restart, input bit ack);
    int sets = 0;
    int cyc = 0;
    do_reset();
    cfg(field);
    while (sets < nsets && cyc < 4000) begin
      sample((gap_every == 0) ? 1'b1 : ((cyc % gap_every) != gap_every - 1));
      cyc++;
      if (done) begin
        done = 1'b0;
        dump(set_base, (sets == 0) ? {stag, " R1 first set"} : stag);
        sets++;
        if (ack) begin
          host_ack = 1'b1;
          @(negedge clk);
          host_ack = 1'b0;
          dr_exp = 1'b0;
          chk("R8 ack clears", int'(data_ready), 0);
        end
        if (restart && sets == 1) cfg(field);
      end
    end
    chk({"completed sets ", stag}, sets, nsets);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    run(3,   3, 0, "R2 period 4",          1'b0, 1'b0);
    run(5,   3, 3, "R2 period 6 gaps",     1'b0, 1'b1);
    run(0,   3, 0, "R10 period 1",         1'b0, 1'b0);
    run(1,   3, 4, "R10 period 2 gaps",    1'b0, 1'b1);
    run(2,   3, 0, "R10 period 3",         1'b0, 1'b0);
    run(4,   3, 0, "R2 period 5",          1'b0, 1'b1);
    run(9,   3, 0, "R11 restart",          1'b1, 1'b0);
    run(9,   3, 5, "R2 period 10 gaps",    1'b0, 1'b0);
    run(63,  3, 0, "R2 period 64",         1'b0, 1'b1);
    run(255, 3, 0, "R3 period 256",        1'b0, 1'b0);
    run(255, 2, 3, "R3 period 256 gaps",   1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule